// File: doc/BRIEF.md
# Serial-Load Display Output Register

This block drives 32 active-high segment or grid enables from a three-wire serial link made of a serial data line, a shift clock and a load envelope. While the envelope is high, each rising shift-clock edge moves one data bit into an internal 32-stage shift register. When the envelope falls, the shift register contents are copied into an output latch. The latch drives the outputs, so the display keeps showing the old pattern while a new one is shifted in.

A blank input turns every output off at once. It does not touch the stored pattern, and it works whether or not a load is in progress. A serial data output carries the bit in the last shift stage and updates on falling shift-clock edges, so several blocks can be chained on one link.

The serial signals are asynchronous to the chip. They are sampled by a fast system clock through two-flop synchronizers, and their edges are detected in that clock domain.

Top module: `serial_display_reg`

## Requirements
- R1: After a load of 32 bits, the k-th bit shifted in after the envelope rose (k counted from 0) appears on `drv_o[k]`, and a latched 1 drives that output high.
- R2: A rising shift-clock edge seen while the envelope is high shifts one bit into the register.
- R3: Shift-clock edges seen while the envelope is low have no effect on the shift register or on the serial output.
- R4: The output latch loads only on a falling envelope edge, so the outputs keep the previous pattern throughout a transfer.
- R5: While blank is 1, all outputs are 0. Blank does not alter the stored pattern, which returns when blank goes back to 0, including a pattern loaded while blank was high.
- R6: `ser_dat_o` presents the last shift stage, which is the next bit to leave the register. It changes only on a falling shift-clock edge accepted while the envelope is high.
- R7: Two blocks chained through `ser_dat_o` act as one 64-bit register: of 64 bits shifted in, the first 32 land in the downstream block and the last 32 in the upstream block.
- R8: After reset, all outputs and `ser_dat_o` are 0.
- R9: Shifting in 32 zeros and then dropping the envelope clears every output.
- R10: The outputs take the new pattern on the third system clock edge after the envelope pin falls, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the serial link |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data in |
| ser_en_i | input | 1 | Load envelope: gates the shift clock, latches on its falling edge |
| blank_i | input | 1 | 1 forces all outputs off |
| ser_dat_o | output | 1 | Cascade data out, last shift stage |
| drv_o | output | N_OUT | Active-high output enables |

## Verification
A walking one over all 32 positions shows that every bit lands at the right output, with no shifts, swaps or reversed order. Arithmetic mixed patterns catch bits that are merged or stuck. Shift-clock toggles with the envelope low are replayed into a relatch, which shows whether they touched the shift register. Partial loads, the cycle-exact envelope-fall timing, blank toggling and a 64-bit load through a second chained block separate the latch timing, the masking and the cascade path.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  typedef struct packed {
    logic blank;
    logic en;
    logic dat;
    logic sclk;
  } sdr_pins_t;
  localparam int unsigned PINS_W = $bits(sdr_pins_t);
endpackage

// File: rtl/sdr_sync.sv
module sdr_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else            stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sdr_edge.sv
module sdr_edge
  import sdr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  sdr_pins_t pins_i,
  output logic      shift_o,
  output logic      fall_o,
  output logic      load_o
);
  sdr_pins_t prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pins_i;
  end

  // envelope gates both shift-clock edges
  assign shift_o = pins_i.en &  pins_i.sclk & ~prev_q.sclk;
  assign fall_o  = pins_i.en & ~pins_i.sclk &  prev_q.sclk;
  assign load_o  = prev_q.en & ~pins_i.en;
endmodule

// File: rtl/sdr_shift.sv
module sdr_shift #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         fall_i,
  input  logic         din_i,
  output logic [N-1:0] q_o,
  output logic         dout_o
);
  logic [N-1:0] sr_q;
  logic         dout_q;

  // oldest bit drifts toward index 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {din_i, sr_q[N-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dout_q <= 1'b0;
    else if (fall_i) dout_q <= sr_q[0];
  end

  assign q_o    = sr_q;
  assign dout_o = dout_q;

  // R2
  shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> sr_q[N-1] == $past(din_i));
  // R3
  no_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(sr_q));
  // R6
  dout_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> $stable(dout_o));
endmodule

// File: rtl/sdr_latch.sv
module sdr_latch #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         blank_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] drv_o
);
  logic [N-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lat_q <= '0;
    else if (load_i) lat_q <= d_i;
  end

  assign drv_o = blank_i ? '0 : lat_q;

  // R4
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(lat_q));
  // R5
  blank_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |-> drv_o == '0);
  // R5
  blank_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blank_i && $past(blank_i) && !$past(load_i)) |-> drv_o == $past(lat_q));
endmodule

// File: rtl/serial_display_reg.sv
module serial_display_reg
  import sdr_pkg::*;
#(
  parameter int unsigned N_OUT       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_clk_i,
  input  logic             ser_dat_i,
  input  logic             ser_en_i,
  input  logic             blank_i,
  output logic             ser_dat_o,
  output logic [N_OUT-1:0] drv_o
);
  sdr_pins_t  raw, syn;
  logic [PINS_W-1:0] syn_bits;
  logic       shift, fall, load;
  logic [N_OUT-1:0] sr;

  assign raw = '{blank: blank_i, en: ser_en_i, dat: ser_dat_i, sclk: ser_clk_i};

  sdr_sync #(.W(PINS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(syn_bits)
  );
  assign syn = sdr_pins_t'(syn_bits);

  sdr_edge u_edge (
    .clk_i, .rst_ni, .pins_i(syn), .shift_o(shift), .fall_o(fall), .load_o(load)
  );

  sdr_shift #(.N(N_OUT)) u_shift (
    .clk_i, .rst_ni, .shift_i(shift), .fall_i(fall), .din_i(syn.dat),
    .q_o(sr), .dout_o(ser_dat_o)
  );

  sdr_latch #(.N(N_OUT)) u_latch (
    .clk_i, .rst_ni, .load_i(load), .blank_i(syn.blank), .d_i(sr), .drv_o(drv_o)
  );

  // R3
  gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !syn.en |-> !shift && !fall);
  // R4
  load_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> !load);
endmodule

// File: tb/tb_serial_display_reg.sv
module tb_serial_display_reg;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, sdat = 0, sen = 0, blank = 0;
  logic dout, dout_b;
  logic [31:0] drv, drv_b;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_display_reg dut (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat),
    .ser_en_i(sen), .blank_i(blank), .ser_dat_o(dout), .drv_o(drv)
  );
  serial_display_reg dut_b (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sclk), .ser_dat_i(dout),
    .ser_en_i(sen), .blank_i(blank), .ser_dat_o(dout_b), .drv_o(drv_b)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    repeat (4) @(negedge clk);
  endtask

  task automatic shift_bits(logic [63:0] w, int n);
    for (int i = 0; i < n; i++) begin
      sdat = w[i]; step();
      sclk = 1;    step();
      sclk = 0;    step();
    end
  endtask

  task automatic load(logic [63:0] w, int n);
    sen = 1; step();
    shift_bits(w, n);
    sen = 0; step();
  endtask

  initial begin
    logic [31:0] a, b;
    repeat (5) @(negedge clk);
    rst_n = 1;
    step();
    chk("R8 drv", drv, 32'h0);
    chk("R8 dout", {31'b0, dout}, 32'h0);

    // R1 walking one
    for (int k = 0; k < 32; k++) begin
      load(64'(32'h1 << k), 32);
      chk("R1 walk", drv, 32'h1 << k);
    end
    // R1 R2 mixed patterns
    for (int k = 1; k <= 8; k++) begin
      a = 32'(k) * 32'h9E3779B9 ^ 32'(k << 5);
      load(64'(a), 32);
      chk("R1 R2 pattern", drv, a);
    end

    // R4 outputs hold during transfer; R10 latency
    a = 32'hA5C3_0F96; b = 32'h1234_FEDC;
    load(64'(a), 32);
    sen = 1; step();
    shift_bits(64'(b), 16);
    chk("R4 mid", drv, a);
    shift_bits(64'(b >> 16), 16);
    chk("R4 end", drv, a);
    sen = 0;
    @(negedge clk); @(negedge clk);
    chk("R10 early", drv, a);
    @(negedge clk);
    chk("R10 edge", drv, b);
    step();

    // R3 clocks with envelope low ignored
    a = 32'h0000_8001;
    load(64'(a), 32);
    for (int i = 0; i < 32; i++) begin
      sdat = 1; step(); sclk = 1; step(); sclk = 0; step();
    end
    chk("R3 dout", {31'b0, dout}, {31'b0, a[0]});
    sen = 1; step(); sen = 0; step();
    chk("R3 relatch", drv, a);

    // R6 dout changes on falling edge only
    a = 32'h0000_0002;
    load(64'(a), 32);
    chk("R6 last", {31'b0, dout}, 32'h0);
    sen = 1; step();
    sdat = 1; step(); sclk = 1; step();
    chk("R6 rise", {31'b0, dout}, 32'h0);
    sclk = 0; step();
    chk("R6 fall", {31'b0, dout}, 32'h1);
    sen = 0; step();

    // R7 chain
    load(64'hDEAD_BEEF_0BAD_F00D, 64);
    chk("R7 up", drv, 32'hDEAD_BEEF);
    chk("R7 down", drv_b, 32'h0BAD_F00D);

    // R5 blank
    a = 32'h3C3C_5AA5; b = 32'hC0FF_EE11;
    load(64'(a), 32);
    blank = 1; step();
    chk("R5 off", drv, 32'h0);
    blank = 0; step();
    chk("R5 back", drv, a);
    blank = 1; step();
    load(64'(b), 32);
    chk("R5 off load", drv, 32'h0);
    blank = 0; step();
    chk("R5 new", drv, b);

    // R9 flush
    load(64'hFFFF_FFFF, 32);
    load(64'h0, 32);
    chk("R9 clear", drv, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule